// File: doc/BRIEF.md
# Dual-Rate Clock Domain Bridge

This block moves data words between a slow clock and a related clock that runs at exactly twice its rate, where the two clocks come from the same source but may arrive with a skew that nobody can bound tightly at design time. The block does not assume that the two sets of rising edges line up. It samples a copy of the slow clock that is delayed by a quarter of its period, using the fast clock. Because that reference changes a quarter period away from every fast edge, each sample is unambiguous. Two consecutive samples tell the fast domain which of its edges falls midway between slow rising edges.

From this phase information the block builds a one-in-two transfer slot in the fast domain. Slow-to-fast words are captured only at the mid-period fast edge, so the capture is far from the slow launch edge. Fast-to-slow words are loaded into a holding register only at that same edge. The register therefore changes a half slow period away from the slow capture edge and stays constant for two fast cycles. A lock flag tells the surrounding logic when the slot is trustworthy. No word moves in either direction while it is low.

Top module: `dual_rate_bridge`

## Requirements
- R1: While reset is asserted and whenever `lock_o` is low, `fast_slot_o`, `fast_valid_o` and `slow_valid_o` are low.
- R2: `lock_o` rises only after the sampled quarter-phase reference has alternated on eight consecutive fast edges (four slow periods), no sooner than 8 and no later than 30 fast cycles after reset release.
- R3: If the sampled reference fails to alternate, `lock_o` and `fast_slot_o` are low within 6 fast cycles. `lock_o` returns once alternation has been seen again for four slow periods.
- R4: While locked, `fast_slot_o` is high on exactly every other fast cycle. It is high in the fast cycle that ends at the fast edge midway between two slow rising edges.
- R5: A word sampled with `slow_valid_i` high at slow edge k is shown on `fast_data_o` with `fast_valid_o` high for exactly one fast cycle. That cycle follows the mid-period fast edge after slow edge k; with slow edge j aligned to fast edge 2j, this is fast edge 2k+1.
- R6: A word presented with `fast_valid_i` high at a fast edge for which `fast_slot_o` was high is shown on `slow_data_o` with `slow_valid_o` high for one slow cycle. It appears at the next slow rising edge.
- R7: `fast_valid_i` and `fast_data_i` presented on a fast cycle where `fast_slot_o` is low have no effect on the slow outputs.
- R8: The fast-to-slow holding register changes only at slot edges, so its contents stay constant for two fast cycles around each slow capture edge.
- R9: With any fixed skew from zero up to just under a quarter slow period, every accepted word crosses exactly once and in order, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_slow_i | input | 1 | Slow (1x) clock |
| clk_fast_i | input | 1 | Fast (2x) clock |
| ref_quad_i | input | 1 | Slow clock delayed by a quarter period, sampled by the fast clock |
| slow_data_i | input | WIDTH | Word from the slow domain toward the fast domain |
| slow_valid_i | input | 1 | Qualifier for `slow_data_i` |
| fast_data_o | output | WIDTH | Word delivered in the fast domain |
| fast_valid_o | output | 1 | One-cycle qualifier for `fast_data_o` |
| fast_data_i | input | WIDTH | Word from the fast domain toward the slow domain |
| fast_valid_i | input | 1 | Qualifier for `fast_data_i`, honoured only in slot cycles |
| fast_slot_o | output | 1 | High in the fast cycle whose closing edge accepts `fast_data_i` |
| slow_data_o | output | WIDTH | Word delivered in the slow domain |
| slow_valid_o | output | 1 | One-cycle qualifier for `slow_data_o` |
| lock_o | output | 1 | Phase relation established (fast domain) |

## Verification
The bench sweeps the clock skew over zero, mid-range and nearly a quarter slow period. It checks the exact fast or slow edge on which each word arrives. A slot placed on the wrong parity of fast edge would show up as an off-by-one arrival, or as data captured in the same instant it launches. Full-rate bursts in both directions would expose a holding register that changes on every fast edge, because the slow side would then lose or duplicate words. A phase that only offers fast words outside the slot must deliver nothing; a bridge that ignored the slot would leak them. Freezing the reference must drop lock, and the bench then expects lock to return. A tracker that never checks alternation would keep transferring with a stale phase.

// File: rtl/drb_pkg.sv
`timescale 1ns/1ps
package drb_pkg;
  // Default word width for both directions.
  localparam int unsigned DRB_WIDTH = 16;
  // Slow periods of clean reference alternation required before lock.
  localparam int unsigned DRB_LOCK_PERIODS = 4;
  // Depth of each reset release chain.
  localparam int unsigned DRB_RST_STAGES = 2;
endpackage

// File: rtl/drb_rst_sync.sv
`timescale 1ns/1ps
module drb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/drb_phase_track.sv
`timescale 1ns/1ps
module drb_phase_track #(
  parameter int unsigned LOCK_PERIODS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic lock_o,
  output logic slot_o
);
  localparam int unsigned TARGET = 2 * LOCK_PERIODS;
  localparam int unsigned CW     = $clog2(TARGET + 1);
  localparam logic [CW-1:0] TGT  = CW'(TARGET);

  // samp_q[0] is the raw capture, [1] and [2] are the settled history.
  logic [2:0]    samp_q, samp_d;
  logic [CW-1:0] run_q, run_d;
  logic          lock_q, lock_d;
  logic          flip;

  always_comb begin
    samp_d = {samp_q[1:0], ref_i};
    flip   = samp_q[1] ^ samp_q[2];
    run_d  = '0;
    if (flip) begin
      run_d = (run_q == TGT) ? run_q : run_q + CW'(1);
    end
    lock_d = flip && (run_d == TGT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  // The oldest sample was taken at an edge aligned with a slow rising edge
  // (reference low there), so the edge about to come is the mid-period one.
  assign lock_o = lock_q;
  assign slot_o = lock_q & ~samp_q[2];

  AST_SLOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |=> !slot_o); // R4
  AST_SLOT_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !slot_o) |=> (slot_o || !lock_o)); // R4
  AST_LOCK_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && (samp_q[1] == samp_q[2])) |=> !lock_o); // R3
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(run_q) >= TGT - CW'(1))); // R2
endmodule

// File: rtl/drb_fwd.sv
`timescale 1ns/1ps
module drb_fwd #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_slow_i,
  input  logic             rst_slow_ni,
  input  logic             clk_fast_i,
  input  logic             rst_fast_ni,
  input  logic             slot_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  // Slow-domain launch register.
  logic [WIDTH-1:0] ld_q, ld_d;
  logic             lv_q, lv_d;
  // Fast-domain capture register.
  logic [WIDTH-1:0] od_q, od_d;
  logic             ov_q, ov_d;

  always_comb begin
    ld_d = data_i;
    lv_d = valid_i;
  end

  always_ff @(posedge clk_slow_i or negedge rst_slow_ni) begin
    if (!rst_slow_ni) begin
      ld_q <= '0;
      lv_q <= 1'b0;
    end else begin
      ld_q <= ld_d;
      lv_q <= lv_d;
    end
  end

  always_comb begin
    od_d = slot_i ? ld_q : od_q;
    ov_d = slot_i & lv_q;
  end

  always_ff @(posedge clk_fast_i or negedge rst_fast_ni) begin
    if (!rst_fast_ni) begin
      od_q <= '0;
      ov_q <= 1'b0;
    end else begin
      od_q <= od_d;
      ov_q <= ov_d;
    end
  end

  assign data_o  = od_q;
  assign valid_o = ov_q;

  AST_FAST_PULSE: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
    valid_o |=> !valid_o); // R5
  AST_FAST_DATA_HOLD: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
    !slot_i |=> $stable(data_o)); // R5
endmodule

// File: rtl/drb_rev.sv
`timescale 1ns/1ps
module drb_rev #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_fast_i,
  input  logic             rst_fast_ni,
  input  logic             clk_slow_i,
  input  logic             rst_slow_ni,
  input  logic             slot_i,
  input  logic             lock_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             valid_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  // Fast-domain holding register, written only in slot cycles.
  logic [WIDTH-1:0] hd_q, hd_d;
  logic             hv_q, hv_d;
  // Slow-domain capture register.
  logic [WIDTH-1:0] sd_q, sd_d;
  logic             sv_q, sv_d;

  always_comb begin
    hd_d = slot_i ? data_i : hd_q;
    if (slot_i) begin
      hv_d = valid_i;
    end else if (lock_i) begin
      hv_d = hv_q;
    end else begin
      hv_d = 1'b0;
    end
  end

  always_ff @(posedge clk_fast_i or negedge rst_fast_ni) begin
    if (!rst_fast_ni) begin
      hd_q <= '0;
      hv_q <= 1'b0;
    end else begin
      hd_q <= hd_d;
      hv_q <= hv_d;
    end
  end

  always_comb begin
    sd_d = hd_q;
    sv_d = hv_q;
  end

  always_ff @(posedge clk_slow_i or negedge rst_slow_ni) begin
    if (!rst_slow_ni) begin
      sd_q <= '0;
      sv_q <= 1'b0;
    end else begin
      sd_q <= sd_d;
      sv_q <= sv_d;
    end
  end

  assign data_o  = sd_q;
  assign valid_o = sv_q;

  AST_HOLD_TWO_CYCLES: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
    (lock_i && !slot_i) |=> ($stable(hd_q) && $stable(hv_q))); // R8
  AST_HOLD_CLEAR_UNLOCKED: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
    !lock_i |=> !hv_q); // R3
endmodule

// File: rtl/dual_rate_bridge.sv
`timescale 1ns/1ps
module dual_rate_bridge #(
  parameter int unsigned WIDTH        = drb_pkg::DRB_WIDTH,
  parameter int unsigned LOCK_PERIODS = drb_pkg::DRB_LOCK_PERIODS,
  parameter int unsigned RST_STAGES   = drb_pkg::DRB_RST_STAGES
) (
  input  logic             rst_ni,
  input  logic             clk_slow_i,
  input  logic             clk_fast_i,
  input  logic             ref_quad_i,
  input  logic [WIDTH-1:0] slow_data_i,
  input  logic             slow_valid_i,
  output logic [WIDTH-1:0] fast_data_o,
  output logic             fast_valid_o,
  input  logic [WIDTH-1:0] fast_data_i,
  input  logic             fast_valid_i,
  output logic             fast_slot_o,
  output logic [WIDTH-1:0] slow_data_o,
  output logic             slow_valid_o,
  output logic             lock_o
);
  logic rst_slow_n;
  logic rst_fast_n;
  logic slot;
  logic lock;

  drb_rst_sync #(.STAGES(RST_STAGES)) u_rst_slow (
    .clk_i   (clk_slow_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_slow_n)
  );

  drb_rst_sync #(.STAGES(RST_STAGES)) u_rst_fast (
    .clk_i   (clk_fast_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_fast_n)
  );

  drb_phase_track #(.LOCK_PERIODS(LOCK_PERIODS)) u_phase (
    .clk_i  (clk_fast_i),
    .rst_ni (rst_fast_n),
    .ref_i  (ref_quad_i),
    .lock_o (lock),
    .slot_o (slot)
  );

  drb_fwd #(.WIDTH(WIDTH)) u_fwd (
    .clk_slow_i  (clk_slow_i),
    .rst_slow_ni (rst_slow_n),
    .clk_fast_i  (clk_fast_i),
    .rst_fast_ni (rst_fast_n),
    .slot_i      (slot),
    .data_i      (slow_data_i),
    .valid_i     (slow_valid_i),
    .data_o      (fast_data_o),
    .valid_o     (fast_valid_o)
  );

  drb_rev #(.WIDTH(WIDTH)) u_rev (
    .clk_fast_i  (clk_fast_i),
    .rst_fast_ni (rst_fast_n),
    .clk_slow_i  (clk_slow_i),
    .rst_slow_ni (rst_slow_n),
    .slot_i      (slot),
    .lock_i      (lock),
    .data_i      (fast_data_i),
    .valid_i     (fast_valid_i),
    .data_o      (slow_data_o),
    .valid_o     (slow_valid_o)
  );

  assign fast_slot_o = slot;
  assign lock_o      = lock;

  AST_NO_SLOT_UNLOCKED: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_n)
    !lock_o |-> !fast_slot_o); // R1
endmodule

// File: tb/test_dual_rate_bridge.sv
`timescale 1ns/1ps
module test_dual_rate_bridge;
  localparam int W = 16;

  logic         rst_n, clk1x, clk2x, clkq;
  logic [W-1:0] sdi, fdo, fdi, sdo;
  logic         svi, fvo, fvi, slot, svo, lock;

  real skew;
  bit  ref_hold;
  int  n1, n2;
  int  errors, checks;
  int  smode, spct, fmode, fpct;
  int  up_seen, dn_seen, off_offers, svo_off;

  typedef struct {logic [W-1:0] d; int idx;} item_t;
  item_t up_q[$];
  item_t dn_q[$];

  dual_rate_bridge #(.WIDTH(W)) i_dual_rate_bridge (
    .rst_ni       (rst_n),
    .clk_slow_i   (clk1x),
    .clk_fast_i   (clk2x),
    .ref_quad_i   (clkq),
    .slow_data_i  (sdi),
    .slow_valid_i (svi),
    .fast_data_o  (fdo),
    .fast_valid_o (fvo),
    .fast_data_i  (fdi),
    .fast_valid_i (fvi),
    .fast_slot_o  (slot),
    .slow_data_o  (sdo),
    .slow_valid_o (svo),
    .lock_o       (lock)
  );

  // Fast clock: 100 MHz, rising edge m at 10*m + 5 ns.
  initial begin
    clk2x = 1'b0;
    forever #5 clk2x = ~clk2x;
  end

  // Slow clock edge k at 20*k + 5 + skew; quarter-phase copy 5 ns later.
  initial begin
    int k;
    k = 0;
    clk1x = 1'b0;
    clkq  = 1'b0;
    forever begin
      #((20.0 * k + 5.0 + skew) - $realtime);
      clk1x = 1'b1;
      #5;
      if (!ref_hold) clkq = 1'b1;
      #5;
      clk1x = 1'b0;
      #5;
      if (!ref_hold) clkq = 1'b0;
      k++;
    end
  end

  initial begin n1 = 0; n2 = 0; end
  always @(posedge clk1x) n1 <= n1 + 1;
  always @(posedge clk2x) n2 <= n2 + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Fast edge on which a word registered at slow edge k is captured (R5).
  function automatic int fast_arrival(int k);
    return 2 * k + 1;
  endfunction

  // Value of the slow edge counter when a word accepted at fast edge m is visible (R6).
  function automatic int slow_arrival(int m);
    return (m + 1) / 2 + 1;
  endfunction

  // Slow-side source.
  initial begin
    svi = 1'b0;
    sdi = '0;
    forever begin
      @(posedge clk1x);
      #3;
      svi = 1'b0;
      if (smode == 2 || (smode == 1 && int'($urandom % 100) < spct)) begin
        sdi = W'($urandom);
        svi = 1'b1;
        up_q.push_back('{sdi, fast_arrival(n1)});
      end
    end
  end

  // Fast-side source.
  initial begin
    fvi = 1'b0;
    fdi = '0;
    forever begin
      bit offer;
      @(posedge clk2x);
      #2;
      fvi = 1'b0;
      case (fmode)
        1:       offer = int'($urandom % 100) < fpct;
        2:       offer = !slot;
        3:       offer = slot;
        default: offer = 1'b0;
      endcase
      if (offer) begin
        fdi = W'($urandom);
        fvi = 1'b1;
        if (slot) dn_q.push_back('{fdi, slow_arrival(n2)});
        else      off_offers++;
      end
    end
  end

  // Fast-side monitor.
  initial begin
    bit prev_lock;
    prev_lock = 1'b0;
    forever begin
      item_t it;
      @(posedge clk2x);
      #5;
      if (lock && prev_lock)
        check(slot == ((n2 - 1) % 2 == 0), "R4", "slot phase", slot, ((n2 - 1) % 2 == 0));
      prev_lock = lock;
      if (fvo) begin
        up_seen++;
        if (up_q.size() == 0) begin
          check(1'b0, "R9", "unexpected fast word", fdo, 0);
        end else begin
          it = up_q.pop_front();
          check(fdo == it.d, "R5", "fast data", fdo, it.d);
          check(n2 - 1 == it.idx, "R5", "fast arrival edge", n2 - 1, it.idx);
        end
      end
    end
  end

  // Slow-side monitor.
  initial begin
    forever begin
      item_t it;
      @(posedge clk1x);
      #5;
      if (svo) begin
        dn_seen++;
        if (fmode == 2) svo_off++;
        if (dn_q.size() == 0) begin
          check(1'b0, "R7/R9", "unexpected slow word", sdo, 0);
        end else begin
          it = dn_q.pop_front();
          check(sdo == it.d, "R6", "slow data", sdo, it.d);
          check(n1 == it.idx, "R6", "slow arrival edge", n1, it.idx);
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic wait_lock(string what);
    int  cyc;
    bit  got;
    int  early;
    cyc = 0; got = 1'b0; early = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(posedge clk2x);
      #1;
      if (lock) begin
        got = 1'b1;
        cyc = i + 1;
      end else if (slot || fvo || svo) begin
        early++;
      end
    end
    check(got, "R2", {what, " lock reached"}, got, 1);
    check(cyc >= 8 && cyc <= 30, "R2", {what, " cycles to lock"}, cyc, 12);
    check(early == 0, "R1", {what, " activity before lock"}, early, 0);
  endtask

  task automatic traffic(int periods, int sp, int fp);
    spct = sp; fpct = fp;
    smode = 1; fmode = 1;
    repeat (periods) @(posedge clk1x);
    smode = 0; fmode = 0;
    repeat (8) @(posedge clk1x);
    check(up_q.size() == 0, "R9", "slow-to-fast backlog", up_q.size(), 0);
    check(dn_q.size() == 0, "R9", "fast-to-slow backlog", dn_q.size(), 0);
  endtask

  initial begin
    real skews [4];
    void'($urandom(32'h5eed));
    skews = '{1.5, 0.0, 3.0, 4.0};
    errors = 0; checks = 0;
    skew = 1.5; ref_hold = 1'b0;
    smode = 0; fmode = 0; spct = 0; fpct = 0;
    up_seen = 0; dn_seen = 0; off_offers = 0; svo_off = 0;
    rst_n = 1'b0;
    #42;
    check(lock == 1'b0, "R1", "lock in reset", lock, 0);
    check(slot == 1'b0, "R1", "slot in reset", slot, 0);
    check(fvo == 1'b0, "R1", "fast valid in reset", fvo, 0);
    check(svo == 1'b0, "R1", "slow valid in reset", svo, 0);
    #10;
    rst_n = 1'b1;
    wait_lock("initial");

    // Random traffic at several skews.
    foreach (skews[i]) begin
      skew = skews[i];
      repeat (4) @(posedge clk1x);
      traffic(250, 30 + 15 * i, 20 + 10 * i);
    end

    // Directed: full rate both ways at the largest skew (R8).
    smode = 2; fmode = 3;
    repeat (40) @(posedge clk1x);
    smode = 0; fmode = 0;
    repeat (8) @(posedge clk1x);
    check(dn_q.size() == 0, "R8", "full-rate fast-to-slow drained", dn_q.size(), 0);
    check(up_q.size() == 0, "R9", "full-rate slow-to-fast drained", up_q.size(), 0);

    // Directed: fast words offered only outside the slot (R7).
    svo_off = 0; off_offers = 0;
    fmode = 2;
    repeat (40) @(posedge clk1x);
    fmode = 0;
    repeat (4) @(posedge clk1x);
    check(svo_off == 0, "R7", "slow words from off-slot offers", svo_off, 0);
    check(off_offers > 0, "R7", "off-slot offers made", off_offers, 1);

    // Directed: freeze the reference, expect lock loss and recovery (R3).
    @(posedge clk2x);
    #1;
    ref_hold = 1'b1;
    repeat (6) @(posedge clk2x);
    #1;
    check(lock == 1'b0, "R3", "lock with frozen reference", lock, 0);
    check(slot == 1'b0, "R3", "slot with frozen reference", slot, 0);
    check(fvo == 1'b0, "R3", "fast valid with frozen reference", fvo, 0);
    ref_hold = 1'b0;
    wait_lock("recovery");
    check(lock == 1'b1, "R3", "lock regained", lock, 1);

    skew = 2.5;
    repeat (4) @(posedge clk1x);
    traffic(200, 60, 40);

    check(up_seen > 100, "R9", "slow-to-fast words delivered", up_seen, 100);
    check(dn_seen > 100, "R9", "fast-to-slow words delivered", dn_seen, 100);
    summary();
    $finish;
  end
endmodule